// File: doc/BRIEF.md
# Sixteen-Channel Monitor Byte Handshake

This block moves multi-byte messages one byte at a time over sixteen independent monitor channels. Each channel is one slot of a repeating frame. A one-hot slot strobe, driven by external framing logic, marks which channel's slot is on the line in the current cycle. In every slot the line carries a data byte, a transmit-valid flag and a receive-acknowledge flag in each direction.

On the transmit side, the host names a channel and supplies a byte. It also supplies a send flag. Only a request with the send flag set starts a transfer. A request with the flag clear only replaces the stored byte. The channel then repeats the byte with its valid flag set in every one of its slots until the far end acknowledges it. A per-channel done bit then tells the host it may load the next byte of the message.

On the receive side, a byte counts only when it arrives identical in two consecutive valid slots. An accepted byte is stored per channel. Its channel number is queued as an event, and the interrupt line stays raised while any event waits. The acknowledge back to the sender is withheld until the host has read that channel's stored byte. This paces the remote side to the host's reading speed.

Top module: `mon_hshake`

## Requirements
- R1: After reset, `irq` is 0, every bit of `tx_done` is 0, and with no slot strobe the line outputs show `line_tx_vld`=0, `line_tx_ack`=0 and `line_tx_byte`=all ones.
- R2: A request with `host_tx_send`=1 makes that channel drive `line_tx_vld`=1 and the loaded byte in its slots. A request with `host_tx_send`=0 only stores the byte, and the channel keeps `line_tx_vld`=0 with the byte field all ones.
- R3: A sending channel repeats its byte in every slot. It completes only on a slot with `line_rx_ack`=1, and only after at least one earlier slot of that transfer has shown `line_rx_ack`=0. On completion the valid flag drops and `tx_done` for that channel goes to 1 in the cycle after that slot. A new send clears the bit.
- R4: A received byte is accepted only when two consecutive slots of the same channel both carry `line_rx_vld`=1 with equal bytes. A slot with `line_rx_vld`=0 clears the comparison history.
- R5: Each acceptance queues its channel number. `irq` is 1 from the cycle after acceptance for as long as the queue holds an entry. `irq_ch` shows the oldest entry, and a cycle with `host_evt_pop`=1 removes that entry.
- R6: `line_tx_ack` stays 0 in a channel's slots after acceptance until the host reads that channel with `host_rd`. `rd_byte` holds the stored byte from the cycle after the read, and changes only after a read.
- R7: Once raised, a channel's acknowledge stays 1 through the first following slot that shows `line_rx_vld`=0, and is 0 afterwards. A byte sent after that must again arrive twice to be accepted.
- R8: Events leave the queue in order of acceptance. While the queue is full, a double arrival is not accepted and no acknowledge is given. The same byte is accepted in the first slot of that channel that arrives after room appears.
- R9: Line inputs in cycles without a slot strobe have no effect on any output or channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_tx_req | input | 1 | Load request for a transmit byte |
| host_tx_ch | input | 4 | Channel for the load request |
| host_tx_byte | input | 8 | Byte to transmit |
| host_tx_send | input | 1 | 1: start sending the byte; 0: store only |
| tx_done | output | 16 | Per channel: last byte acknowledged by the remote side |
| host_rd | input | 1 | Read request for a received byte |
| host_rd_ch | input | 4 | Channel to read |
| rd_byte | output | 8 | Byte returned by the last read |
| irq | output | 1 | High while receive events are queued |
| irq_ch | output | 4 | Channel of the oldest queued event |
| host_evt_pop | input | 1 | Remove the oldest event |
| slot_stb | input | 16 | One-hot slot strobe, bit k marks channel k |
| line_rx_byte | input | 8 | Incoming data byte of the current slot |
| line_rx_vld | input | 1 | Incoming valid flag |
| line_rx_ack | input | 1 | Incoming acknowledge flag |
| line_tx_byte | output | 8 | Outgoing data byte for the current slot |
| line_tx_vld | output | 1 | Outgoing valid flag |
| line_tx_ack | output | 1 | Outgoing acknowledge flag |

## Verification
The line outputs are combinational from registered channel state, so the bench samples them one nanosecond after it asserts a strobe within the same cycle. Everything a slot changes (`tx_done`, acceptance, acknowledge state) is due at the next rising edge, and the bench reads it only after that edge. `rd_byte` is due one edge after `host_rd` and is read at the following falling edge. Queue events appear on `irq` one edge after the accepting slot. A monitor compares them at falling edges against a scoreboard queue that the driver fills before each accepting slot, and it pops them one event per cycle.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;

    typedef enum logic [1:0] {
        TX_IDLE     = 2'd0,
        TX_WAIT_CLR = 2'd1,
        TX_WAIT_ACK = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT      = 2'd0,
        RX_WAIT_READ = 2'd1,
        RX_ACKING    = 2'd2
    } rx_state_e;

endpackage

// File: rtl/mon_tx_chan.sv
module mon_tx_chan
    import mon_hs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              send_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              stb_i,
    input  logic              ack_i,
    output logic              vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              done_o
);

    typedef struct packed {
        tx_state_e         st;
        logic [BYTE_W-1:0] data;
        logic              done;
    } tx_s_t;

    tx_s_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            // a load always replaces the byte; only a send restarts the transfer
            s_d.data = byte_i;
            if (send_i) begin
                s_d.st   = TX_WAIT_CLR;
                s_d.done = 1'b0;
            end
        end else if (stb_i) begin
            unique case (s_q.st)
                TX_WAIT_CLR: if (!ack_i) s_d.st = TX_WAIT_ACK;
                TX_WAIT_ACK: if (ack_i) begin
                    s_d.st   = TX_IDLE;
                    s_d.done = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: TX_IDLE, data: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign vld_o  = (s_q.st != TX_IDLE);
    assign byte_o = vld_o ? s_q.data : {BYTE_W{1'b1}};
    assign done_o = s_q.done;

endmodule

// File: rtl/mon_rx_chan.sv
module mon_rx_chan
    import mon_hs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic              vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              room_i,
    input  logic              rd_hit_i,
    output logic              acc_o,
    output logic              ack_o,
    output logic [BYTE_W-1:0] data_o
);

    typedef struct packed {
        rx_state_e         st;
        logic [BYTE_W-1:0] last;
        logic              have;
        logic [BYTE_W-1:0] data;
    } rx_s_t;

    rx_s_t s_d, s_q;
    logic  acc;

    always_comb begin
        s_d = s_q;
        acc = 1'b0;
        unique case (s_q.st)
            RX_HUNT: begin
                if (stb_i) begin
                    if (!vld_i) begin
                        s_d.have = 1'b0;
                    end else if (s_q.have && (byte_i == s_q.last)) begin
                        // second identical arrival; take it only if the event queue has space
                        if (room_i) begin
                            acc       = 1'b1;
                            s_d.data  = byte_i;
                            s_d.st    = RX_WAIT_READ;
                            s_d.have  = 1'b0;
                        end
                    end else begin
                        s_d.last = byte_i;
                        s_d.have = 1'b1;
                    end
                end
            end
            RX_WAIT_READ: begin
                if (rd_hit_i) s_d.st = RX_ACKING;
            end
            RX_ACKING: begin
                if (stb_i && !vld_i) begin
                    s_d.st   = RX_HUNT;
                    s_d.have = 1'b0;
                end
            end
            default: s_d.st = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: RX_HUNT, last: '0, have: 1'b0, data: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_o  = acc;
    assign ack_o  = (s_q.st == RX_ACKING);
    assign data_o = s_q.data;

endmodule

// File: rtl/mon_evt_fifo.sv
module mon_evt_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic         empty_o,
    output logic         full_o,
    output logic [W-1:0] head_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_s_t;

    fifo_s_t s_d, s_q;
    logic    do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_push = push_i && (s_q.cnt != FULL_CNT);
        do_pop  = pop_i && (s_q.cnt != '0);
        if (do_push) begin
            s_d.mem[s_q.wr] = data_i;
            s_d.wr = (s_q.wr == LAST_IDX) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == LAST_IDX) ? '0 : s_q.rd + 1'b1;
        end
        if (do_push && !do_pop) s_d.cnt = s_q.cnt + 1'b1;
        if (do_pop && !do_push) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == FULL_CNT);
    assign head_o  = empty_o ? '0 : s_q.mem[s_q.rd];

endmodule

// File: rtl/mon_hshake.sv
module mon_hshake
    import mon_hs_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int BYTE_W    = 8,
    parameter int EVQ_DEPTH = 4,
    localparam int CH_W     = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_tx_req,
    input  logic [CH_W-1:0]   host_tx_ch,
    input  logic [BYTE_W-1:0] host_tx_byte,
    input  logic              host_tx_send,
    output logic [NCH-1:0]    tx_done,
    input  logic              host_rd,
    input  logic [CH_W-1:0]   host_rd_ch,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              irq,
    output logic [CH_W-1:0]   irq_ch,
    input  logic              host_evt_pop,
    input  logic [NCH-1:0]    slot_stb,
    input  logic [BYTE_W-1:0] line_rx_byte,
    input  logic              line_rx_vld,
    input  logic              line_rx_ack,
    output logic [BYTE_W-1:0] line_tx_byte,
    output logic              line_tx_vld,
    output logic              line_tx_ack
);

    logic [NCH-1:0]             tx_vld_vec;
    logic [NCH-1:0][BYTE_W-1:0] tx_byte_vec;
    logic [NCH-1:0]             acc_vec;
    logic [NCH-1:0]             ack_vec;
    logic [NCH-1:0][BYTE_W-1:0] rx_data_vec;
    logic                       evq_full;
    logic                       evq_empty;
    logic                       acc_any;
    logic [CH_W-1:0]            acc_ch;

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        mon_tx_chan #(.BYTE_W(BYTE_W)) u_tx (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (host_tx_req && (host_tx_ch == CH_W'(k))),
            .send_i (host_tx_send),
            .byte_i (host_tx_byte),
            .stb_i  (slot_stb[k]),
            .ack_i  (line_rx_ack),
            .vld_o  (tx_vld_vec[k]),
            .byte_o (tx_byte_vec[k]),
            .done_o (tx_done[k])
        );

        mon_rx_chan #(.BYTE_W(BYTE_W)) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .stb_i    (slot_stb[k]),
            .vld_i    (line_rx_vld),
            .byte_i   (line_rx_byte),
            .room_i   (!evq_full),
            .rd_hit_i (host_rd && (host_rd_ch == CH_W'(k))),
            .acc_o    (acc_vec[k]),
            .ack_o    (ack_vec[k]),
            .data_o   (rx_data_vec[k])
        );
    end

    // slot multiplexer and acceptance encoder; strobes are one-hot so at most one term contributes
    always_comb begin
        line_tx_byte = {BYTE_W{1'b1}};
        line_tx_vld  = 1'b0;
        line_tx_ack  = 1'b0;
        acc_any      = 1'b0;
        acc_ch       = '0;
        for (int k = 0; k < NCH; k++) begin
            if (slot_stb[k]) begin
                line_tx_byte = tx_byte_vec[k];
                line_tx_vld  = tx_vld_vec[k];
                line_tx_ack  = ack_vec[k];
            end
            if (acc_vec[k]) begin
                acc_any = 1'b1;
                acc_ch  = CH_W'(k);
            end
        end
    end

    mon_evt_fifo #(.DEPTH(EVQ_DEPTH), .W(CH_W)) u_evq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (acc_any),
        .data_i  (acc_ch),
        .pop_i   (host_evt_pop),
        .empty_o (evq_empty),
        .full_o  (evq_full),
        .head_o  (irq_ch)
    );

    assign irq = !evq_empty;

    typedef struct packed {
        logic [BYTE_W-1:0] rd_byte;
    } top_s_t;

    top_s_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (host_rd) begin
            for (int k = 0; k < NCH; k++) begin
                if (host_rd_ch == CH_W'(k)) s_d.rd_byte = rx_data_vec[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_byte = s_q.rd_byte;

endmodule

// File: rtl/mon_hshake_chk.sv
module mon_hshake_chk #(
    parameter int NCH    = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    slot_stb,
    input logic              line_rx_vld,
    input logic              line_rx_ack,
    input logic              line_tx_vld,
    input logic              line_tx_ack,
    input logic [BYTE_W-1:0] line_tx_byte,
    input logic [NCH-1:0]    tx_done,
    input logic              irq,
    input logic              host_rd,
    input logic [BYTE_W-1:0] rd_byte,
    input logic [NCH-1:0]    ack_vec,
    input logic [NCH-1:0]    acc_vec,
    input logic              evq_full
);

    assert_one_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_stb));

    assert_quiet_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb == '0) |-> (!line_tx_vld && !line_tx_ack && (line_tx_byte == '1)));

    assert_done_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_done & ~$past(tx_done))) |-> $past(line_rx_ack && (|slot_stb)));

    assert_irq_from_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(line_rx_vld && (|slot_stb)));

    assert_ack_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_vec & ~$past(ack_vec))) |-> $past(host_rd));

    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_rd) |-> $stable(rd_byte));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evq_full |-> (acc_vec == '0));

endmodule

bind mon_hshake mon_hshake_chk #(.NCH(NCH), .BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_stb     (slot_stb),
    .line_rx_vld  (line_rx_vld),
    .line_rx_ack  (line_rx_ack),
    .line_tx_vld  (line_tx_vld),
    .line_tx_ack  (line_tx_ack),
    .line_tx_byte (line_tx_byte),
    .tx_done      (tx_done),
    .irq          (irq),
    .host_rd      (host_rd),
    .rd_byte      (rd_byte),
    .ack_vec      (ack_vec),
    .acc_vec      (acc_vec),
    .evq_full     (evq_full)
);

// File: tb/sim_mon_hshake.sv
`timescale 1ns/100ps
module sim_mon_hshake;

    localparam int NCH  = 16;
    localparam int BW   = 8;
    localparam int CW   = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_tx_req, host_tx_send, host_rd, host_evt_pop;
    logic [CW-1:0] host_tx_ch, host_rd_ch;
    logic [BW-1:0] host_tx_byte;
    logic [NCH-1:0] tx_done;
    logic [BW-1:0] rd_byte;
    logic          irq;
    logic [CW-1:0] irq_ch;
    logic [NCH-1:0] slot_stb;
    logic [BW-1:0] line_rx_byte, line_tx_byte;
    logic          line_rx_vld, line_rx_ack, line_tx_vld, line_tx_ack;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    logic pop_en = 1'b1;
    logic s_vld, s_ack;
    logic [BW-1:0] s_byte;

    always #2.5 clk = ~clk;

    mon_hshake u0 (
        .clk(clk), .rst_n(rst_n),
        .host_tx_req(host_tx_req), .host_tx_ch(host_tx_ch), .host_tx_byte(host_tx_byte),
        .host_tx_send(host_tx_send), .tx_done(tx_done),
        .host_rd(host_rd), .host_rd_ch(host_rd_ch), .rd_byte(rd_byte),
        .irq(irq), .irq_ch(irq_ch), .host_evt_pop(host_evt_pop),
        .slot_stb(slot_stb), .line_rx_byte(line_rx_byte), .line_rx_vld(line_rx_vld),
        .line_rx_ack(line_rx_ack), .line_tx_byte(line_tx_byte), .line_tx_vld(line_tx_vld),
        .line_tx_ack(line_tx_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one slot of channel ch; line outputs captured mid-cycle, state settled on return
    task automatic slot(input int ch, input logic v, input logic a, input logic [BW-1:0] b);
        @(negedge clk);
        slot_stb     = NCH'(1) << ch;
        line_rx_vld  = v;
        line_rx_ack  = a;
        line_rx_byte = b;
        #1;
        s_vld  = line_tx_vld;
        s_ack  = line_tx_ack;
        s_byte = line_tx_byte;
        @(posedge clk);
        #1;
        slot_stb = '0;
    endtask

    task automatic tx_load(input int ch, input logic [BW-1:0] b, input logic snd);
        @(negedge clk);
        host_tx_req  = 1'b1;
        host_tx_ch   = CW'(ch);
        host_tx_byte = b;
        host_tx_send = snd;
        @(posedge clk);
        #1;
        host_tx_req = 1'b0;
    endtask

    task automatic rd_chan(input int ch);
        @(negedge clk);
        host_rd    = 1'b1;
        host_rd_ch = CW'(ch);
        @(posedge clk);
        #1;
        host_rd = 1'b0;
        @(negedge clk);
    endtask

    // scoreboard monitor: compares and removes one queued event per cycle
    always @(negedge clk) begin : mon
        int e;
        host_evt_pop = 1'b0;
        if (rst_n && pop_en && irq) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected event", int'(irq_ch), -1);
            end else begin
                e = exp_q.pop_front();
                chk("R5/R8 event channel", int'(irq_ch), e);
            end
            host_evt_pop = 1'b1;
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        host_tx_req = 0; host_tx_send = 0; host_rd = 0;
        host_tx_ch = '0; host_rd_ch = '0; host_tx_byte = '0;
        slot_stb = '0; line_rx_byte = '0; line_rx_vld = 0; line_rx_ack = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", irq, 0);
        chk("R1 tx_done", int'(tx_done), 0);
        chk("R1 line vld", line_tx_vld, 0);
        chk("R1 line ack", line_tx_ack, 0);
        chk("R1 line byte", line_tx_byte, 8'hFF);

        // transmit with send set, repeated until ack
        tx_load(3, 8'hA5, 1'b1);
        slot(3, 0, 0, 8'h00);
        chk("R2 vld", s_vld, 1);
        chk("R2 byte", s_byte, 8'hA5);
        slot(3, 0, 0, 8'h00);
        chk("R3 repeat vld", s_vld, 1);
        chk("R3 not done", tx_done[3], 0);
        slot(3, 0, 1, 8'h00);
        chk("R3 vld in ack slot", s_vld, 1);
        chk("R3 done", tx_done[3], 1);
        slot(3, 0, 0, 8'h00);
        chk("R3 vld dropped", s_vld, 0);
        chk("R3 idle byte", s_byte, 8'hFF);

        // stale acknowledge must first go low
        tx_load(6, 8'h66, 1'b1);
        slot(6, 0, 1, 8'h00);
        chk("R3 stale ack ignored", tx_done[6], 0);
        slot(6, 0, 0, 8'h00);
        slot(6, 0, 1, 8'h00);
        chk("R3 done after fresh ack", tx_done[6], 1);
        tx_load(6, 8'h67, 1'b1);
        chk("R3 new send clears done", tx_done[6], 0);

        // store without send
        tx_load(5, 8'h3C, 1'b0);
        slot(5, 0, 0, 8'h00);
        chk("R2 no send vld", s_vld, 0);
        chk("R2 no send byte", s_byte, 8'hFF);

        // inputs without strobe
        @(negedge clk);
        line_rx_vld = 1; line_rx_ack = 1; line_rx_byte = 8'h99;
        repeat (3) @(negedge clk);
        line_rx_vld = 1; line_rx_byte = 8'h99;
        repeat (2) @(negedge clk);
        chk("R9 no irq", irq, 0);
        chk("R9 vld", line_tx_vld, 0);
        chk("R9 ack", line_tx_ack, 0);
        slot(6, 0, 0, 8'h00);
        chk("R9 ch6 still sending", s_vld, 1);

        // receive: differing bytes are not accepted
        slot(2, 1, 0, 8'h11);
        slot(2, 1, 0, 8'h22);
        @(negedge clk);
        chk("R4 differing bytes", irq, 0);
        // gap clears history
        slot(4, 1, 0, 8'h44);
        slot(4, 0, 0, 8'h00);
        slot(4, 1, 0, 8'h44);
        @(negedge clk);
        chk("R4 gap clears history", irq, 0);
        exp_q.push_back(2);
        slot(2, 1, 0, 8'h22);
        slot(2, 1, 0, 8'h22);
        chk("R6 ack withheld", s_ack, 0);
        rd_chan(2);
        chk("R6 read data", rd_byte, 8'h22);
        slot(2, 1, 0, 8'h22);
        chk("R6 ack after read", s_ack, 1);
        slot(2, 0, 0, 8'h00);
        chk("R7 ack in release slot", s_ack, 1);
        slot(2, 1, 0, 8'h22);
        chk("R7 ack cleared", s_ack, 0);
        repeat (2) @(negedge clk);
        chk("R7 single arrival no event", irq, 0);
        exp_q.push_back(2);
        slot(2, 1, 0, 8'h22);
        repeat (3) @(negedge clk);
        chk("R7 second arrival accepted", exp_q.size(), 0);

        // queue fill and deferral
        pop_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int c = 7; c <= 10; c++) begin
            exp_q.push_back(c);
            slot(c, 1, 0, BW'(c * 16));
            slot(c, 1, 0, BW'(c * 16));
        end
        @(negedge clk);
        chk("R5 irq pending", irq, 1);
        chk("R5 oldest channel", irq_ch, 7);
        slot(11, 1, 0, 8'h5A);
        slot(11, 1, 0, 8'h5A);
        rd_chan(11);
        slot(11, 1, 0, 8'h5A);
        chk("R8 deferred no ack", s_ack, 0);
        pop_en = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 in-order drain", exp_q.size(), 0);
        chk("R8 deferred not queued", irq, 0);
        exp_q.push_back(11);
        slot(11, 1, 0, 8'h5A);
        repeat (4) @(negedge clk);
        chk("R8 accepted after room", exp_q.size(), 0);
        rd_chan(11);
        chk("R8 deferred byte stored", rd_byte, 8'h5A);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule